// File: doc/BRIEF.md
# Priority Interrupt Collector with Level Acknowledge

This block gathers a wide vector of level-sensitive peripheral interrupt lines and drives a single interrupt request toward the CPU. Every source owns a small control word that holds an enable bit and a priority. Each cycle the block picks the pending, enabled source with the greatest priority and shows its number in a status word. If no source qualifies, the status word shows a reserved "no source" code.

Software services a request in two steps. First it writes anything to the vector register. That drops the request line and places the serviced priority level in service. While a level is in service, only sources of strictly greater priority can interrupt again, which allows nesting. When the handler is done, software writes a one-hot mask to the level-acknowledge register, and each set bit frees one level. Software never sees a list of pending sources, only the single selected vector.

Top module: `intc_levelack`

## Requirements
- R1: After reset, `irq_out` is low, the status word (address 0x400) reads 0x7F, and every source word reads 0.
- R2: Source i has its word at byte address i*0x10. A plain write there stores bits [1:0] as the priority (0 lowest, 3 highest) and bit 4 as the enable. A read returns these two fields with every other bit 0.
- R3: A write to source address +0x4 ORs the written priority and enable bits into the word. A write to +0x8 clears the bits that are 1 in the written data.
- R4: A source whose enable bit is 0 never raises `irq_out` and never appears in the status word, even while its line is high.
- R5: Interrupt lines pass through two synchroniser flops and a selection register. A line first sampled high at rising edge k raises `irq_out` after edge k+2 and not earlier. The status word bits [6:0] then carry the source number.
- R6: Among eligible sources the highest priority wins. Among equal priorities the lowest source number wins.
- R7: The status word reads 0x7F whenever no request is live, and `irq_out` is high only while a valid source is selected.
- R8: A write of any value to the vector register (0x410) while a request is live drops `irq_out` right after that clock edge. It also puts that request's priority level in service. No level enters service without such a write.
- R9: While any level is in service, a source raises `irq_out` only if its priority is strictly above the highest in-service level.
- R10: A write to the level-acknowledge register (0x420) frees every level l for which data bit l is 1. All other levels stay in service.
- R11: If a line falls before service, `irq_out` falls and the status word returns to 0x7F. A vector write made in that state puts no level in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 11 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | 64 | Level-sensitive peripheral interrupt lines |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The bound checker watches the link between the selector and the level tracker on every cycle. It confirms four things: the request line is never high without a selected source, a vector write always places exactly one level in service and leaves no equal or lower request live, no level enters service without a vector write, and an acknowledge clears every level it names. The bench scenarios are needed for the behaviours a single-cycle property cannot judge. These are the register layout with its set and clear aliases, the exact synchroniser latency, the tie-break by source number, nesting, partial acknowledges, and the spurious case where the line vanishes before service.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // Width of the reported vector number and the reserved no-source code
   localparam int                VEC_W    = 7;
   localparam logic [VEC_W-1:0]  VEC_NONE = 7'h7F;

   // Bit position of the enable flag inside a source word
   localparam int                ENA_BIT  = 4;

   // Control-area register slots (address bits [5:4] inside the area)
   localparam logic [1:0]        CTL_STATUS = 2'd0;
   localparam logic [1:0]        CTL_VECTOR = 2'd1;
   localparam logic [1:0]        CTL_LVLACK = 2'd2;

   // Kind of access to a source word, decoded from address bits [3:2]
   typedef enum logic [1:0] {
      ACC_WRITE = 2'd0,
      ACC_SET   = 2'd1,
      ACC_CLR   = 2'd2,
      ACC_NONE  = 2'd3
   } acc_e;

endpackage

// File: rtl/intc_src_sync.sv
module intc_src_sync #(
   parameter int N_SRC  = 64,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] raw,
   output logic [N_SRC-1:0] synced
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign synced = raw;
      end else begin : g_chain
         logic [N_SRC-1:0] stage_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[s] <= '0;
                  else        stage_q[s] <= raw;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stage_q[s] <= '0;
                  else        stage_q[s] <= stage_q[s-1];
               end
            end
         end
         assign synced = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/intc_src_regs.sv
module intc_src_regs
   import intc_pkg::*;
#(
   parameter int N_SRC  = 64,
   parameter int PRIO_W = 2,
   localparam int IDX_W = $clog2(N_SRC)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  acc_e                          wr_acc,
   input  logic [31:0]                   wr_data,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [N_SRC-1:0]              en_vec,
   output logic [N_SRC-1:0][PRIO_W-1:0]  prio_vec,
   output logic [31:0]                   rd_word
);

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         logic              en_r;
         logic [PRIO_W-1:0] prio_r;
         logic              hit;

         assign hit = wr_en && (wr_idx == IDX_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_r   <= 1'b0;
               prio_r <= '0;
            end else if (hit) begin
               unique case (wr_acc)
                  ACC_WRITE: begin
                     en_r   <= wr_data[ENA_BIT];
                     prio_r <= wr_data[PRIO_W-1:0];
                  end
                  ACC_SET: begin
                     en_r   <= en_r | wr_data[ENA_BIT];
                     prio_r <= prio_r | wr_data[PRIO_W-1:0];
                  end
                  ACC_CLR: begin
                     en_r   <= en_r & ~wr_data[ENA_BIT];
                     prio_r <= prio_r & ~wr_data[PRIO_W-1:0];
                  end
                  default: begin
                     en_r   <= en_r;
                     prio_r <= prio_r;
                  end
               endcase
            end
         end

         assign en_vec[i]   = en_r;
         assign prio_vec[i] = prio_r;
      end
   endgenerate

   always_comb begin
      rd_word                = '0;
      rd_word[ENA_BIT]       = en_vec[rd_idx];
      rd_word[PRIO_W-1:0]    = prio_vec[rd_idx];
   end

endmodule

// File: rtl/intc_level_track.sv
module intc_level_track #(
   parameter int N_PRIO = 4,
   localparam int PRIO_W = $clog2(N_PRIO)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mark,
   input  logic [PRIO_W-1:0] mark_lvl,
   input  logic              ack_wr,
   input  logic [N_PRIO-1:0] ack_mask,
   output logic [N_PRIO-1:0] in_service,
   output logic [N_PRIO-1:0] blocked
);

   logic [N_PRIO-1:0] mark_hot;

   assign mark_hot = mark ? (N_PRIO'(1) << mark_lvl) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      in_service <= '0;
      else if (ack_wr) in_service <= in_service & ~ack_mask;
      else             in_service <= in_service | mark_hot;
   end

   // A level is blocked when it or any level above it is in service
   generate
      for (genvar l = 0; l < N_PRIO; l++) begin : g_blk
         assign blocked[l] = |(in_service >> l);
      end
   endgenerate

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
   parameter int N_SRC  = 64,
   parameter int N_PRIO = 4,
   localparam int IDX_W  = $clog2(N_SRC),
   localparam int PRIO_W = $clog2(N_PRIO)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_SRC-1:0]              req,
   input  logic [N_SRC-1:0]              en,
   input  logic [N_SRC-1:0][PRIO_W-1:0]  prio,
   input  logic [N_PRIO-1:0]             blocked,
   output logic                          sel_valid,
   output logic [IDX_W-1:0]              sel_id,
   output logic [PRIO_W-1:0]             sel_prio
);

   logic [N_SRC-1:0]  elig;
   logic              found;
   logic [IDX_W-1:0]  best_id;
   logic [PRIO_W-1:0] best_p;

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_elig
         assign elig[i] = req[i] & en[i] & ~blocked[prio[i]];
      end
   endgenerate

   // Strictly-greater update keeps the lowest index among equal priorities
   always_comb begin
      found   = 1'b0;
      best_id = '0;
      best_p  = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (elig[i] && (!found || (prio[i] > best_p))) begin
            found   = 1'b1;
            best_id = IDX_W'(i);
            best_p  = prio[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_valid <= 1'b0;
         sel_id    <= '0;
         sel_prio  <= '0;
      end else begin
         sel_valid <= found;
         sel_id    <= best_id;
         sel_prio  <= best_p;
      end
   end

endmodule

// File: rtl/intc_levelack.sv
module intc_levelack
   import intc_pkg::*;
#(
   parameter int N_SRC       = 64,
   parameter int N_PRIO      = 4,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W  = $clog2(N_SRC),
   localparam int PRIO_W = $clog2(N_PRIO),
   localparam int AW     = IDX_W + 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [N_SRC-1:0] irq_lines,
   output logic             irq_out
);

   generate
      if (N_SRC < 2 || N_SRC > 127 || (1 << IDX_W) != N_SRC) begin : g_bad_src
         $error("N_SRC must be a power of two between 2 and 64");
      end
      if (N_PRIO < 2 || N_PRIO > 16 || (1 << PRIO_W) != N_PRIO) begin : g_bad_prio
         $error("N_PRIO must be a power of two between 2 and 16");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 4");
      end
   endgenerate

   // Address decode
   logic              ctl_area;
   logic              ctl_hit;
   logic [1:0]        ctl_slot;
   logic [IDX_W-1:0]  src_idx;
   acc_e              src_acc;
   logic              src_wr;
   logic              vec_wr;
   logic              ack_wr;

   assign ctl_area = bus_addr[AW-1];
   assign ctl_slot = bus_addr[5:4];
   assign ctl_hit  = ctl_area && (bus_addr[3:0] == 4'd0) &&
                     (bus_addr[AW-2:6] == '0);
   assign src_idx  = bus_addr[AW-2:4];
   assign src_acc  = acc_e'(bus_addr[3:2]);
   assign src_wr   = bus_wr && !ctl_area && (src_acc != ACC_NONE);
   assign vec_wr   = bus_wr && ctl_hit && (ctl_slot == CTL_VECTOR);
   assign ack_wr   = bus_wr && ctl_hit && (ctl_slot == CTL_LVLACK);

   // Datapath
   logic [N_SRC-1:0]              lines_s;
   logic [N_SRC-1:0]              en_vec;
   logic [N_SRC-1:0][PRIO_W-1:0]  prio_vec;
   logic [31:0]                   src_word;
   logic [N_PRIO-1:0]             in_service;
   logic [N_PRIO-1:0]             blocked;
   logic                          sel_valid;
   logic [IDX_W-1:0]              sel_id;
   logic [PRIO_W-1:0]             sel_prio;
   logic                          live;

   intc_src_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (irq_lines),
      .synced (lines_s)
   );

   intc_src_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (src_wr),
      .wr_idx   (src_idx),
      .wr_acc   (src_acc),
      .wr_data  (bus_wdata),
      .rd_idx   (src_idx),
      .en_vec   (en_vec),
      .prio_vec (prio_vec),
      .rd_word  (src_word)
   );

   intc_arbiter #(.N_SRC(N_SRC), .N_PRIO(N_PRIO)) arb_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (lines_s),
      .en        (en_vec),
      .prio      (prio_vec),
      .blocked   (blocked),
      .sel_valid (sel_valid),
      .sel_id    (sel_id),
      .sel_prio  (sel_prio)
   );

   // A registered pick is live only while its level is not blocked now
   assign live    = sel_valid && !blocked[sel_prio];
   assign irq_out = live;

   intc_level_track #(.N_PRIO(N_PRIO)) lvl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mark       (vec_wr && live),
      .mark_lvl   (sel_prio),
      .ack_wr     (ack_wr),
      .ack_mask   (bus_wdata[N_PRIO-1:0]),
      .in_service (in_service),
      .blocked    (blocked)
   );

   // Read mux
   always_comb begin
      bus_rdata = '0;
      if (ctl_area) begin
         if (ctl_hit && (ctl_slot == CTL_STATUS))
            bus_rdata[VEC_W-1:0] = live ? VEC_W'(sel_id) : VEC_NONE;
      end else if (src_acc != ACC_NONE) begin
         bus_rdata = src_word;
      end
   end

endmodule

// File: rtl/intc_levelack_chk.sv
module intc_levelack_chk #(
   parameter int N_PRIO = 4,
   localparam int PRIO_W = $clog2(N_PRIO)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_out,
   input logic              sel_valid,
   input logic [PRIO_W-1:0] sel_prio,
   input logic [N_PRIO-1:0] in_service,
   input logic              vec_wr,
   input logic              ack_wr,
   input logic [N_PRIO-1:0] ack_mask
);

   AST_IRQ_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> sel_valid); // R7

   AST_VEC_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_wr && irq_out) |=> in_service[$past(sel_prio)]); // R8

   AST_VEC_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_wr && irq_out) |=> (!irq_out || (sel_prio > $past(sel_prio)))); // R9

   AST_NO_LEVEL_WITHOUT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      ((in_service & ~$past(in_service)) != '0) |-> $past(vec_wr)); // R8

   AST_ONE_LEVEL_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_service & ~$past(in_service)) <= 1); // R8

   AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> ((in_service & $past(ack_mask)) == '0)); // R10

endmodule

bind intc_levelack intc_levelack_chk #(.N_PRIO(N_PRIO)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_out    (irq_out),
   .sel_valid  (sel_valid),
   .sel_prio   (sel_prio),
   .in_service (in_service),
   .vec_wr     (vec_wr),
   .ack_wr     (ack_wr),
   .ack_mask   (bus_wdata[N_PRIO-1:0])
);

// File: tb/intc_levelack_tb_top.sv
module intc_levelack_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [10:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] irq_lines = '0;
   logic        irq_out;

   localparam logic [10:0] A_STATUS = 11'h400;
   localparam logic [10:0] A_VECTOR = 11'h410;
   localparam logic [10:0] A_LVLACK = 11'h420;

   always #10 clk = ~clk;

   intc_levelack dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_lines (irq_lines),
      .irq_out   (irq_out)
   );

   typedef struct {
      string       req;
      logic [31:0] exp;
      bit          is_irq;
   } sb_item_t;

   sb_item_t sb_q[$];
   int       n_run  = 0;
   int       n_fail = 0;
   bit       done   = 1'b0;

   // Monitor: pops each expected item and compares against the outputs
   initial begin
      forever begin
         sb_item_t    it;
         logic [31:0] act;
         wait (sb_q.size() > 0);
         it  = sb_q.pop_front();
         act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
         end
      end
   end

   // Driver tasks; all are entered just after a falling edge
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [10:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic expect_reg(input string req, input logic [10:0] a, input logic [31:0] e);
      bus_addr = a;
      #2;
      sb_q.push_back('{req, e, 1'b0});
      #1;
   endtask

   task automatic expect_irq(input string req, input logic e);
      #2;
      sb_q.push_back('{req, {31'b0, e}, 1'b1});
      #1;
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state
      expect_irq("R1 irq after reset", 1'b0);
      expect_reg("R1 status after reset", A_STATUS, 32'h7F);
      expect_reg("R1 source word after reset", 11'h050, 32'h0);

      // R2: plain write and readback, field masking
      wr(11'h050, 32'h11);
      expect_reg("R2 src5 readback", 11'h050, 32'h11);
      wr(11'h090, 32'hFFFF_FFEE);
      expect_reg("R2 src9 masked fields", 11'h090, 32'h02);

      // R3: set and clear aliases
      wr(11'h094, 32'h10);
      expect_reg("R3 set enable", 11'h090, 32'h12);
      wr(11'h098, 32'h10);
      expect_reg("R3 clear enable", 11'h090, 32'h02);
      wr(11'h098, 32'h3);
      expect_reg("R3 clear priority", 11'h090, 32'h00);
      wr(11'h094, 32'h11);
      expect_reg("R3 set both", 11'h090, 32'h11);

      // R4: disabled source is ignored
      wr(11'h098, 32'h10);
      irq_lines[9] = 1'b1;
      idle(5);
      expect_irq("R4 disabled src irq", 1'b0);
      expect_reg("R4 disabled src status", A_STATUS, 32'h7F);
      irq_lines[9] = 1'b0;
      idle(4);

      // R5: synchroniser latency
      irq_lines[5] = 1'b1;
      idle(2);
      expect_irq("R5 irq not yet", 1'b0);
      idle(1);
      expect_irq("R5 irq raised", 1'b1);
      expect_reg("R5 status vector", A_STATUS, 32'd5);

      // R8: vector write drops irq, level 1 in service
      wr(A_VECTOR, 32'hDEAD_BEEF);
      expect_irq("R8 irq dropped", 1'b0);
      expect_reg("R8 status after vector", A_STATUS, 32'h7F);

      // R9: equal priority blocked, higher priority nests
      wr(11'h090, 32'h11);
      irq_lines[9] = 1'b1;
      idle(4);
      expect_irq("R9 equal prio blocked", 1'b0);
      wr(11'h140, 32'h12);
      irq_lines[20] = 1'b1;
      idle(4);
      expect_irq("R9 higher prio nests", 1'b1);
      expect_reg("R9 nested vector", A_STATUS, 32'd20);
      wr(A_VECTOR, 32'h0);
      expect_irq("R9 nested irq dropped", 1'b0);

      // R10: one-hot acknowledge frees only named levels
      wr(A_LVLACK, 32'h4);
      idle(2);
      expect_irq("R10 level2 freed", 1'b1);
      expect_reg("R10 src20 again", A_STATUS, 32'd20);
      wr(A_VECTOR, 32'h0);
      wr(A_LVLACK, 32'h2);
      idle(3);
      expect_irq("R10 level2 still held", 1'b0);
      wr(A_LVLACK, 32'h4);
      idle(2);
      expect_reg("R6 highest prio wins", A_STATUS, 32'd20);

      // R6: tie among priority 1 goes to lowest number
      irq_lines[20] = 1'b0;
      idle(4);
      expect_reg("R6 tie lowest number", A_STATUS, 32'd5);
      wr(11'h030, 32'h13);
      irq_lines[3] = 1'b1;
      idle(4);
      expect_reg("R6 prio3 over prio1", A_STATUS, 32'd3);

      // R7: no request leaves the reserved code
      irq_lines[3] = 1'b0;
      irq_lines[5] = 1'b0;
      irq_lines[9] = 1'b0;
      idle(4);
      expect_irq("R7 idle irq", 1'b0);
      expect_reg("R7 idle status", A_STATUS, 32'h7F);

      // R11: spurious request
      irq_lines[5] = 1'b1;
      idle(4);
      expect_reg("R11 before withdraw", A_STATUS, 32'd5);
      irq_lines[5] = 1'b0;
      idle(4);
      expect_irq("R11 irq fell", 1'b0);
      expect_reg("R11 status spurious", A_STATUS, 32'h7F);
      wr(A_VECTOR, 32'h0);
      irq_lines[9] = 1'b1;
      idle(4);
      expect_irq("R11 no level marked", 1'b1);
      expect_reg("R11 src9 served", A_STATUS, 32'd9);
      wr(A_VECTOR, 32'h0);
      wr(A_LVLACK, 32'h2);
      irq_lines[9] = 1'b0;
      idle(4);
      expect_irq("R11 final idle", 1'b0);

      wait (sb_q.size() == 0);
      #1;
      done = 1'b1;
      summary();
   end

endmodule